// File: doc/BRIEF.md
# Dual-Prescaler Free-Running Timer

A memory-mapped up-counter for system timekeeping. Software reads a free-running count through a bank of ten 32-bit word registers. The count is advanced by one of two clock sources. The first is the system (peripheral) clock, divided by a 12-bit prescaler. The second is a slower oscillator, modelled as a one-cycle tick input in the system clock domain. The oscillator path passes through a 4-bit prescaler and then through the same 12-bit stage, so the two dividers multiply.

Three compare registers each raise a status flag when the count reaches their value. Software clears a flag by writing 1 to it. The interrupt output combines the flags with per-flag enables. With free-run off, the first compare register sets the counter's period. A self-clearing soft reset returns the whole block to its reset state. Software starts it by writing the reset bit and then polls that bit until it reads back 0.

Top module: `dual_presc_timer`

## Requirements
- R1: After the asynchronous reset, every register word reads 0 and `irq_o` is low.
- R2: Word addresses are 0 ctrl, 1 presc, 2 stat, 3 irq_en, 4..6 cmp0..cmp2, 7..8 capture, 9 count, and words 10..15 read 0. The capture words always read 0 and ignore writes. The count word is read-only. presc keeps bits 15:0, irq_en keeps bits 2:0 and stat uses bits 2:0.
- R3: ctrl fields are bit 0 enable, bits 8:6 source select, bit 9 free-run, bit 10 oscillator enable and bit 15 soft reset. Every other ctrl bit reads 0. While enable is 0 the count holds.
- R4: With source 1 and enable set, the count advances once every P+1 system cycles, where P is presc[11:0]. The first advance comes P+1 cycles after the ctrl write.
- R5: With source 5, enable set and oscillator enable set, the count advances once every (P+1)*(Q+1) oscillator ticks, where Q is presc[15:12]. If oscillator enable is 0, or the source is any value other than 1 or 5, the count never advances.
- R6: With free-run set, the count passes every compare value without effect and wraps from all ones to 0.
- R7: With free-run clear, an advance while the count equals cmp0 takes the count to 0.
- R8: Status bit n (n = 0..2) is set at the advance that makes the count equal to cmpn. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: `irq_o` is high exactly when some status bit n and irq_en bit n are both 1.
- R10: Writing 1 to ctrl bit 15 clears every register, both prescalers and the count. Bit 15 then reads 1 for 4 system cycles after the write edge and reads 0 from then on. Bus writes made while it reads 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Write strobe, qualified by req_i |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| osc_tick_i | input | 1 | One-cycle oscillator tick, system clock domain |
| irq_o | output | 1 | Compare interrupt |

## Verification
The bench builds the block with an 8-bit counter, so a free-running wrap from 255 to 0 is reached within a few hundred cycles. The prescaler widths stay at 12 and 4 bits and the soft-reset length stays at 4 cycles, so the largest oscillator divider and the exact polling duration are both exercised. Table vectors cross the two sources, oscillator enable, unsupported source codes, free-run against restart and several divider settings. Directed cases cover flag set and clear timing, interrupt masking, sparse oscillator ticks and writes blocked during soft reset.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NUM_CMP = 3;

  typedef enum logic [3:0] {
    A_CTRL  = 4'd0,
    A_PRESC = 4'd1,
    A_STAT  = 4'd2,
    A_IRQEN = 4'd3,
    A_CMP0  = 4'd4,
    A_CMP1  = 4'd5,
    A_CMP2  = 4'd6,
    A_CAP0  = 4'd7,
    A_CAP1  = 4'd8,
    A_COUNT = 4'd9
  } reg_addr_e;

  localparam int unsigned CTRL_EN   = 0;
  localparam int unsigned CTRL_SRC  = 6;
  localparam int unsigned CTRL_FREE = 9;
  localparam int unsigned CTRL_OSC  = 10;
  localparam int unsigned CTRL_SRST = 15;

  localparam logic [2:0]  SRC_PERIPH = 3'd1;
  localparam logic [2:0]  SRC_OSC    = 3'd5;
  localparam logic [31:0] CTRL_WMASK = 32'h0000_07C1;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         tc_o
);
  logic [W-1:0] cnt_q;
  logic         at_lim;

  // >= keeps the stage bounded if the limit is lowered mid-count
  assign at_lim = (cnt_q >= limit_i);
  assign tc_o   = tick_i & at_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= at_lim ? '0 : cnt_q + W'(1);
  end

  // R4: a terminal count restarts the stage
  a_r4_tc_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !clr_i) |=> (cnt_q == '0));
  // R4: no input tick, no movement
  a_r4_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned NCMP  = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  adv_i,
  input  logic                  free_i,
  input  logic [NCMP-1:0][31:0] cmp_i,
  output logic [CNT_W-1:0]      count_o,
  output logic [NCMP-1:0]       hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             at_top;

  assign at_top  = (32'(cnt_q) == cmp_i[0]);
  assign cnt_nxt = (!free_i && at_top) ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_nxt;
  end

  // flag on the advance that lands on the compare value
  for (genvar n = 0; n < NCMP; n++) begin : g_hit
    assign hit_o[n] = adv_i & ~clr_i & (32'(cnt_nxt) == cmp_i[n]);
  end

  assign count_o = cnt_q;

  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i && free_i && cnt_q == '1) |=> (cnt_q == '0));
  a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i && !free_i && 32'(cnt_q) == cmp_i[0]) |=> (cnt_q == '0));
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_srst.sv
module tmr_srst #(
  parameter int unsigned CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(CYC - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CW'(1);
    end
  end

  assign busy_o = busy_q;

  a_r10_ends_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> ($past(cnt_q) == '0));
  a_r10_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i);
endmodule

// File: rtl/dual_presc_timer.sv
module dual_presc_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned MAIN_PS_W = 12,
  parameter int unsigned OSC_PS_W  = 4,
  parameter int unsigned SRST_CYC  = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        osc_tick_i,
  output logic        irq_o
);
  localparam int unsigned PS_W = MAIN_PS_W + OSC_PS_W;

  logic                     busy, clr, wr, srst_start;
  logic [31:0]              ctrl_q;
  logic [PS_W-1:0]          presc_q;
  logic [NUM_CMP-1:0]       stat_q, irq_en_q, hit, w1c;
  logic [NUM_CMP-1:0][31:0] cmp_q;
  logic [CNT_W-1:0]         count;
  logic [2:0]               src;
  logic                     use_per, use_osc, osc_in, osc_tc, main_in, adv;

  assign wr         = req_i & we_i & ~busy;
  assign srst_start = wr && (addr_i == A_CTRL) && wdata_i[CTRL_SRST];
  assign clr        = srst_start | busy;
  assign w1c        = (wr && addr_i == A_STAT) ? wdata_i[NUM_CMP-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      presc_q  <= '0;
      irq_en_q <= '0;
      stat_q   <= '0;
      cmp_q    <= '0;
    end else if (clr) begin
      ctrl_q   <= '0;
      presc_q  <= '0;
      irq_en_q <= '0;
      stat_q   <= '0;
      cmp_q    <= '0;
    end else begin
      stat_q <= (stat_q & ~w1c) | hit;
      if (wr && addr_i == A_CTRL)  ctrl_q   <= wdata_i & CTRL_WMASK;
      if (wr && addr_i == A_PRESC) presc_q  <= wdata_i[PS_W-1:0];
      if (wr && addr_i == A_IRQEN) irq_en_q <= wdata_i[NUM_CMP-1:0];
      for (int n = 0; n < NUM_CMP; n++) begin
        if (wr && addr_i == 4'(A_CMP0 + n)) cmp_q[n] <= wdata_i;
      end
    end
  end

  // clock-enable path selection
  assign src     = ctrl_q[CTRL_SRC +: 3];
  assign use_per = ctrl_q[CTRL_EN] && (src == SRC_PERIPH);
  assign use_osc = ctrl_q[CTRL_EN] && ctrl_q[CTRL_OSC] && (src == SRC_OSC);
  assign osc_in  = use_osc & osc_tick_i;
  assign main_in = use_per | osc_tc;

  tmr_prescaler #(.W(OSC_PS_W)) i_osc_ps (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .tick_i  (osc_in),
    .limit_i (presc_q[MAIN_PS_W +: OSC_PS_W]),
    .tc_o    (osc_tc)
  );

  tmr_prescaler #(.W(MAIN_PS_W)) i_main_ps (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .tick_i  (main_in),
    .limit_i (presc_q[MAIN_PS_W-1:0]),
    .tc_o    (adv)
  );

  tmr_counter #(.CNT_W(CNT_W), .NCMP(NUM_CMP)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .adv_i   (adv),
    .free_i  (ctrl_q[CTRL_FREE]),
    .cmp_i   (cmp_q),
    .count_o (count),
    .hit_o   (hit)
  );

  tmr_srst #(.CYC(SRST_CYC)) i_srst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (srst_start),
    .busy_o  (busy)
  );

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = ctrl_q | (32'(busy) << CTRL_SRST);
      A_PRESC: rdata_o = 32'(presc_q);
      A_STAT:  rdata_o = 32'(stat_q);
      A_IRQEN: rdata_o = 32'(irq_en_q);
      A_CMP0:  rdata_o = cmp_q[0];
      A_CMP1:  rdata_o = cmp_q[1];
      A_CMP2:  rdata_o = cmp_q[2];
      A_COUNT: rdata_o = 32'(count);
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = |(stat_q & irq_en_q);

  a_r10_held_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> (count == '0 && presc_q == '0 && stat_q == '0));
  a_r8_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_STAT && wdata_i[0] && !hit[0]) |=> !stat_q[0]);
  a_r9_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat_q != '0));
  a_r5_osc_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_tc |-> (ctrl_q[CTRL_OSC] && osc_tick_i));
endmodule

// File: tb/test_dual_presc_timer.sv
`timescale 1ns/1ps
module test_dual_presc_timer;
  import tmr_pkg::*;

  localparam int TB_CNT_W = 8;

  logic        clk = 1'b0, rst_ni = 1'b0, req = 1'b0, we = 1'b0, osc_tick = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  dual_presc_timer #(.CNT_W(TB_CNT_W)) i_dual_presc_timer (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .osc_tick_i(osc_tick), .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [2:0]  src;
    logic        osc;
    logic        frr;
    logic [11:0] mps;
    logic [3:0]  ops;
    logic [7:0]  top;
    logic [15:0] cyc;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{3'd1, 1'b0, 1'b1, 12'd0, 4'd0,  8'd0, 16'd10},
    '{3'd1, 1'b0, 1'b1, 12'd2, 4'd0,  8'd0, 16'd20},
    '{3'd1, 1'b0, 1'b1, 12'd9, 4'd0,  8'd0, 16'd95},
    '{3'd5, 1'b1, 1'b1, 12'd1, 4'd2,  8'd0, 16'd30},
    '{3'd5, 1'b1, 1'b1, 12'd0, 4'd15, 8'd0, 16'd64},
    '{3'd5, 1'b0, 1'b1, 12'd0, 4'd0,  8'd0, 16'd20},
    '{3'd2, 1'b1, 1'b1, 12'd0, 4'd0,  8'd0, 16'd20},
    '{3'd1, 1'b0, 1'b0, 12'd0, 4'd0,  8'd5, 16'd20},
    '{3'd1, 1'b0, 1'b1, 12'd0, 4'd0,  8'd0, 16'd300},
    '{3'd5, 1'b1, 1'b0, 12'd1, 4'd1,  8'd3, 16'd54}
  };

  function automatic logic [31:0] model(vec_t v);
    int per, adv;
    if (v.src == 3'd1) per = int'(v.mps) + 1;
    else if (v.src == 3'd5 && v.osc) per = (int'(v.mps) + 1) * (int'(v.ops) + 1);
    else return 32'd0;
    adv = int'(v.cyc) / per;
    if (v.frr) return 32'(adv % (1 << TB_CNT_W));
    return 32'(adv % (int'(v.top) + 1));
  endfunction

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic srst_poll(output int ones);
    logic [31:0] d;
    wr(A_CTRL, 32'h0000_8000);
    ones = 0;
    for (int k = 0; k < 50; k++) begin
      rd(A_CTRL, d);
      if (!d[15]) break;
      ones++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] ctrl_word(logic [2:0] s, logic o, logic f, logic e);
    return (32'(s) << 6) | (32'(f) << 9) | (32'(o) << 10) | 32'(e);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R10: watchdog expired, got hang expected completion");
      report();
    end
  end

  initial begin
    logic [31:0] d;
    int ones;
    string tag;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), d);
      chk($sformatf("R1 word %0d", a), d, 32'd0);
    end
    chk("R1 irq", 32'(irq), 32'd0);

    // R2 map and access rules
    wr(A_CAP0, 32'hFFFF_FFFF);
    wr(A_CAP1, 32'hFFFF_FFFF);
    rd(A_CAP0, d); chk("R2 cap0", d, 32'd0);
    rd(A_CAP1, d); chk("R2 cap1", d, 32'd0);
    wr(A_COUNT, 32'h55);
    rd(A_COUNT, d); chk("R2 count ro", d, 32'd0);
    wr(A_IRQEN, 32'hFF);
    rd(A_IRQEN, d); chk("R2 irq_en width", d, 32'd7);
    wr(A_PRESC, 32'hFFFF_FFFF);
    rd(A_PRESC, d); chk("R2 presc width", d, 32'h0000_FFFF);
    wr(A_CMP2, 32'hDEAD_BEEF);
    rd(A_CMP2, d); chk("R2 cmp2", d, 32'hDEAD_BEEF);
    rd(4'd12, d); chk("R2 unmapped", d, 32'd0);

    // R3 enable off and field mask
    srst_poll(ones);
    wr(A_CTRL, ctrl_word(3'd1, 1'b0, 1'b1, 1'b0));
    repeat (10) @(negedge clk);
    rd(A_COUNT, d); chk("R3 disabled hold", d, 32'd0);
    rd(A_CTRL, d); chk("R3 ctrl readback", d, 32'h0000_0240);
    wr(A_CTRL, 32'hFFFF_7FFE);
    rd(A_CTRL, d); chk("R3 ctrl mask", d, 32'h0000_07C0);

    // table of source / divider / mode vectors
    for (int i = 0; i < NV; i++) begin
      srst_poll(ones);
      wr(A_PRESC, {16'd0, VT[i].ops, VT[i].mps});
      wr(A_CMP0, 32'(VT[i].top));
      wr(A_CTRL, ctrl_word(VT[i].src, VT[i].osc, VT[i].frr, 1'b1));
      osc_tick = 1'b1;
      repeat (int'(VT[i].cyc)) @(negedge clk);
      osc_tick = 1'b0;
      rd(A_COUNT, d);
      if (VT[i].src == 3'd1) tag = VT[i].frr ? ((VT[i].cyc > 16'd255) ? "R6" : "R4") : "R7";
      else tag = "R5";
      chk($sformatf("%s vector %0d", tag, i), d, model(VT[i]));
    end

    // R8 / R9 flags and interrupt
    srst_poll(ones);
    wr(A_CMP0, 32'd3);
    wr(A_CMP1, 32'd5);
    wr(A_CMP2, 32'd200);
    wr(A_IRQEN, 32'd2);
    wr(A_CTRL, ctrl_word(3'd1, 1'b0, 1'b1, 1'b1));
    repeat (5) @(negedge clk);
    rd(A_STAT, d); chk("R8 flags set", d, 32'd3);
    chk("R9 irq on", 32'(irq), 32'd1);
    wr(A_STAT, 32'd0);
    rd(A_STAT, d); chk("R8 write 0 no effect", d, 32'd3);
    wr(A_STAT, 32'd2);
    rd(A_STAT, d); chk("R8 w1c", d, 32'd1);
    chk("R9 irq masked", 32'(irq), 32'd0);
    rd(A_COUNT, d); chk("R4 count at 7", d, 32'd7);
    wr(A_IRQEN, 32'd1);
    chk("R9 irq reenabled", 32'(irq), 32'd1);

    // R7 restart sequence
    srst_poll(ones);
    wr(A_CMP0, 32'd2);
    wr(A_CTRL, ctrl_word(3'd1, 1'b0, 1'b0, 1'b1));
    repeat (2) @(negedge clk);
    rd(A_COUNT, d); chk("R7 at top", d, 32'd2);
    rd(A_STAT, d); chk("R8 top flag", d, 32'd1);
    @(negedge clk);
    rd(A_COUNT, d); chk("R7 back to 0", d, 32'd0);

    // R5 sparse oscillator ticks
    srst_poll(ones);
    wr(A_PRESC, 32'h0000_1000);
    wr(A_CTRL, ctrl_word(3'd5, 1'b1, 1'b1, 1'b1));
    for (int p = 0; p < 7; p++) begin
      osc_tick = 1'b1;
      @(negedge clk);
      osc_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
    rd(A_COUNT, d); chk("R5 sparse ticks", d, 32'd3);

    // R10 soft reset duration and clearing
    wr(A_PRESC, 32'h0000_05A5);
    wr(A_CMP0, 32'h77);
    wr(A_IRQEN, 32'd7);
    srst_poll(ones);
    chk("R10 busy cycles", 32'(ones), 32'd4);
    rd(A_PRESC, d); chk("R10 presc cleared", d, 32'd0);
    rd(A_CMP0, d); chk("R10 cmp0 cleared", d, 32'd0);
    rd(A_IRQEN, d); chk("R10 irq_en cleared", d, 32'd0);
    rd(A_CTRL, d); chk("R10 ctrl cleared", d, 32'd0);
    rd(A_COUNT, d); chk("R10 count cleared", d, 32'd0);

    // R10 writes blocked while busy
    wr(A_CTRL, 32'h0000_8000);
    wr(A_PRESC, 32'h0000_0123);
    ones = 0;
    for (int k = 0; k < 50; k++) begin
      rd(A_CTRL, d);
      if (!d[15]) break;
      ones++;
      @(negedge clk);
    end
    chk("R10 remaining busy", 32'(ones), 32'd3);
    rd(A_PRESC, d); chk("R10 write ignored", d, 32'd0);

    report();
  end
endmodule